// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache with Three-State Line Coherence

This block is a physically addressed, four-way set-associative data cache. It sits between a 32-bit load/store port and a memory port that moves whole lines. With the default settings it holds 128 sets of four lines each. Every line is 32 bytes, held as eight 32-bit words, and carries an address tag and a two-bit coherence state. The state is one of invalid, exclusive or modified.

Each request on the load/store port carries its own policy bits. A write-through bit makes a write go to memory as a single word. A caching-inhibited bit sends the whole access to memory and leaves the array untouched. Misses pick a victim by tree pseudo-LRU, and a modified victim is written back as a full line before the new line is fetched. The block takes one request at a time and lowers `req_ready` until that request's response has been returned.

Top module: `dcm_cache_top`

## Requirements
- R1: An address splits into a byte offset in bits [4:0], a word select in bits [4:2], a set index in bits [11:5] and a tag in bits [31:12]. A line filled for one set serves every word of that line, and a different set index with the same tag is a separate line.
- R2: A cacheable read that hits returns its word with `resp_valid` one cycle after acceptance and causes no memory-port transaction.
- R3: A cacheable read that misses fetches the line with one line read, returns the addressed word, and leaves the line exclusive (state code 2'b01).
- R4: A write-back write hit (`req_wt`=0) updates the word and sets the line modified (state code 2'b11), responding one cycle later with no memory traffic. When a modified line is evicted, its eight words are written back as one line write before the fill line read.
- R5: A write-through write hit updates the cached word, issues one word write to memory, and leaves the line state unchanged. An exclusive line written this way is later evicted without a writeback.
- R6: A write-through write miss issues one word write and allocates no line, so a later read of that address misses.
- R7: A caching-inhibited access (`req_ci`=1) is done as a single word read or word write on the memory port. It allocates no line and changes no PLRU state, so a repeated inhibited read goes to memory again.
- R8: The victim is the lowest-numbered invalid way if one exists. Otherwise it comes from three PLRU bits per set. Bit 0 set means the victim is in ways 2/3. Bit 1 set picks way 1 over way 0, and bit 2 set picks way 3 over way 2. Every hit or fill updates these bits so they point away from the way just used. The bits are all zero after reset.
- R9: A write-back write miss fills the line, merges the written word into it, and leaves the line modified.
- R10: `req_ready` is low from acceptance until the response cycle. The memory port is active only while busy, and a request offered while busy is ignored.
- R11: After reset every line is invalid, `req_ready` is high, and both `resp_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load/store request present |
| req_ready | output | 1 | Cache idle; request accepted this cycle if valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wt | input | 1 | Write-through policy for this access |
| req_ci | input | 1 | Caching-inhibited access |
| req_addr | input | 32 | Physical byte address |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_rdata | output | 32 | Load data (zero for stores) |
| mem_req | output | 1 | Memory transaction requested, held until acknowledged |
| mem_we | output | 1 | 1 = memory write |
| mem_word | output | 1 | 1 = single-word access, 0 = full-line access |
| mem_addr | output | 32 | Line-aligned address for line access, word address otherwise |
| mem_wline | output | 256 | Write data: full line, or word in bits [31:0] |
| mem_ack | input | 1 | Memory completes the held transaction |
| mem_rline | input | 256 | Read data: full line, or word in bits [31:0] |

## Verification
A hit responds one cycle after acceptance. Each memory transaction adds two cycles with the bench's memory, which acknowledges one cycle after it sees a request. So a clean miss responds after 3 cycles, and a miss that evicts a modified line responds after 5. For every operation the bench predicts the response latency as one plus twice the number of expected memory transactions. It counts negative edges from the acceptance edge to the first `resp_valid`, and compares the per-kind memory transaction counts taken over the whole operation. Load data is compared against a flat reference memory, so an eviction that loses written data shows up as a wrong word several operations later.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    localparam int NUM_WAYS = 4;
    localparam int WAY_W    = 2;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_EXC = 2'b01,
        LS_MOD = 2'b11
    } line_st_e;

    typedef enum logic [2:0] {
        CF_IDLE,
        CF_EVICT,
        CF_FILL,
        CF_WORD_WR,
        CF_WORD_RD
    } ctl_fsm_e;

endpackage

// File: rtl/dcm_way_match.sv
module dcm_way_match
    import dcm_pkg::*;
#(
    parameter int TAG_W = 20
) (
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [NUM_WAYS-1:0][1:0]       way_state,
    input  logic [TAG_W-1:0]               look_tag,
    output logic                           hit,
    output logic [WAY_W-1:0]               hit_way
);

    logic [NUM_WAYS-1:0] match;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = (way_state[w] != LS_INV) && (way_tag[w] == look_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/dcm_plru.sv
module dcm_plru
    import dcm_pkg::*;
(
    input  logic [2:0]               cur_bits,
    input  logic [NUM_WAYS-1:0][1:0] way_state,
    input  logic [WAY_W-1:0]         touch_way,
    output logic [WAY_W-1:0]         victim_way,
    output logic [2:0]               next_bits
);

    logic                have_inv;
    logic [WAY_W-1:0]    inv_way;

    always_comb begin
        have_inv = 1'b0;
        inv_way  = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (way_state[w] == LS_INV) begin
                have_inv = 1'b1;
                inv_way  = WAY_W'(w);
            end
        end
    end

    always_comb begin
        if (have_inv) begin
            victim_way = inv_way;
        end else if (cur_bits[0]) begin
            victim_way = {1'b1, cur_bits[2]};
        end else begin
            victim_way = {1'b0, cur_bits[1]};
        end
    end

    always_comb begin
        next_bits    = cur_bits;
        next_bits[0] = ~touch_way[1];
        if (touch_way[1]) begin
            next_bits[2] = ~touch_way[0];
        end else begin
            next_bits[1] = ~touch_way[0];
        end
    end

endmodule

// File: rtl/dcm_line_merge.sv
module dcm_line_merge #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 8,
    localparam int SEL_W  = $clog2(WORDS),
    localparam int LINE_W = DATA_W * WORDS
) (
    input  logic [LINE_W-1:0] line_in,
    input  logic [SEL_W-1:0]  word_sel,
    input  logic [DATA_W-1:0] word_data,
    input  logic              merge_en,
    output logic [LINE_W-1:0] line_out
);

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        assign line_out[k*DATA_W +: DATA_W] =
            (merge_en && (word_sel == SEL_W'(k))) ? word_data : line_in[k*DATA_W +: DATA_W];
    end

endmodule

// File: rtl/dcm_cache_top.sv
module dcm_cache_top
    import dcm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 128,
    parameter int WORDS  = 8,
    localparam int LINE_W = DATA_W * WORDS,
    localparam int OFF_W  = $clog2(WORDS * (DATA_W / 8)),
    localparam int BYTE_W = $clog2(DATA_W / 8),
    localparam int SEL_W  = $clog2(WORDS),
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_wt,
    input  logic              req_ci,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wline,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rline
);

    typedef struct packed {
        ctl_fsm_e          fsm;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              ci;
        logic [WAY_W-1:0]  way;
        logic              resp_valid;
        logic [DATA_W-1:0] resp_rdata;
    } ctl_t;

    ctl_t c_d, c_q;

    // Storage arrays
    logic [TAG_W-1:0]  tag_mem  [SETS][NUM_WAYS];
    logic [1:0]        st_mem   [SETS][NUM_WAYS];
    logic [2:0]        plru_mem [SETS];
    logic [LINE_W-1:0] data_mem [SETS*NUM_WAYS];

    // Lookup address: the incoming request when idle, the held one otherwise
    logic [ADDR_W-1:0] look_addr;
    logic [IDX_W-1:0]  look_set;
    logic [TAG_W-1:0]  look_tag;
    logic [SEL_W-1:0]  look_sel;

    assign look_addr = (c_q.fsm == CF_IDLE) ? req_addr : c_q.addr;
    assign look_set  = look_addr[OFF_W +: IDX_W];
    assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];
    assign look_sel  = look_addr[BYTE_W +: SEL_W];

    logic [NUM_WAYS-1:0][TAG_W-1:0] set_tags;
    logic [NUM_WAYS-1:0][1:0]       set_st;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
        assign set_tags[w] = tag_mem[look_set][w];
        assign set_st[w]   = st_mem[look_set][w];
    end

    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] victim_way;
    logic [WAY_W-1:0] touch_way;
    logic [2:0]       plru_next;

    dcm_way_match #(.TAG_W(TAG_W)) u_match (
        .way_tag   (set_tags),
        .way_state (set_st),
        .look_tag  (look_tag),
        .hit       (hit),
        .hit_way   (hit_way)
    );

    dcm_plru u_plru (
        .cur_bits   (plru_mem[look_set]),
        .way_state  (set_st),
        .touch_way  (touch_way),
        .victim_way (victim_way),
        .next_bits  (plru_next)
    );

    logic [LINE_W-1:0] hit_line;
    logic [LINE_W-1:0] merge_src;
    logic [SEL_W-1:0]  merge_sel;
    logic [DATA_W-1:0] merge_data;
    logic              merge_en;
    logic [LINE_W-1:0] merge_out;

    assign hit_line = data_mem[{look_set, hit_way}];

    dcm_line_merge #(.DATA_W(DATA_W), .WORDS(WORDS)) u_merge (
        .line_in   (merge_src),
        .word_sel  (merge_sel),
        .word_data (merge_data),
        .merge_en  (merge_en),
        .line_out  (merge_out)
    );

    // Array write controls
    logic             data_we;
    logic             tag_we;
    logic             st_we;
    logic [1:0]       st_val;
    logic             plru_we;
    logic [WAY_W-1:0] wr_way;

    always_comb begin
        c_d            = c_q;
        c_d.resp_valid = 1'b0;
        c_d.resp_rdata = '0;
        data_we    = 1'b0;
        tag_we     = 1'b0;
        st_we      = 1'b0;
        st_val     = LS_EXC;
        plru_we    = 1'b0;
        wr_way     = hit_way;
        touch_way  = hit_way;
        merge_src  = hit_line;
        merge_sel  = look_sel;
        merge_data = req_wdata;
        merge_en   = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_word   = 1'b0;
        mem_addr   = {look_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_wline  = '0;

        unique case (c_q.fsm)
            CF_IDLE: begin
                if (req_valid) begin
                    c_d.addr  = req_addr;
                    c_d.wdata = req_wdata;
                    c_d.write = req_write;
                    c_d.ci    = req_ci;
                    if (req_ci) begin
                        c_d.fsm = req_write ? CF_WORD_WR : CF_WORD_RD;
                    end else if (hit) begin
                        plru_we = 1'b1;
                        if (req_write) begin
                            merge_en = 1'b1;
                            data_we  = 1'b1;
                            if (req_wt) begin
                                c_d.fsm = CF_WORD_WR;
                            end else begin
                                st_we          = 1'b1;
                                st_val         = LS_MOD;
                                c_d.resp_valid = 1'b1;
                            end
                        end else begin
                            c_d.resp_valid = 1'b1;
                            c_d.resp_rdata = hit_line[look_sel*DATA_W +: DATA_W];
                        end
                    end else if (req_write && req_wt) begin
                        c_d.fsm = CF_WORD_WR;
                    end else begin
                        c_d.way = victim_way;
                        c_d.fsm = (set_st[victim_way] == LS_MOD) ? CF_EVICT : CF_FILL;
                    end
                end
            end

            CF_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {set_tags[c_q.way], look_set, {OFF_W{1'b0}}};
                mem_wline = data_mem[{look_set, c_q.way}];
                if (mem_ack) c_d.fsm = CF_FILL;
            end

            CF_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    merge_src  = mem_rline;
                    merge_data = c_q.wdata;
                    merge_en   = c_q.write;
                    wr_way     = c_q.way;
                    touch_way  = c_q.way;
                    data_we    = 1'b1;
                    tag_we     = 1'b1;
                    st_we      = 1'b1;
                    st_val     = c_q.write ? LS_MOD : LS_EXC;
                    plru_we    = 1'b1;
                    c_d.resp_valid = 1'b1;
                    c_d.resp_rdata = c_q.write ? '0 : mem_rline[look_sel*DATA_W +: DATA_W];
                    c_d.fsm        = CF_IDLE;
                end
            end

            CF_WORD_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_word  = 1'b1;
                mem_addr  = c_q.addr;
                mem_wline = {{(LINE_W-DATA_W){1'b0}}, c_q.wdata};
                if (mem_ack) begin
                    c_d.resp_valid = 1'b1;
                    c_d.fsm        = CF_IDLE;
                end
            end

            CF_WORD_RD: begin
                mem_req  = 1'b1;
                mem_word = 1'b1;
                mem_addr = c_q.addr;
                if (mem_ack) begin
                    c_d.resp_valid = 1'b1;
                    c_d.resp_rdata = mem_rline[DATA_W-1:0];
                    c_d.fsm        = CF_IDLE;
                end
            end

            default: c_d.fsm = CF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{fsm: CF_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                plru_mem[s] <= '0;
                for (int w = 0; w < NUM_WAYS; w++) begin
                    st_mem[s][w] <= LS_INV;
                end
            end
        end else begin
            if (st_we)   st_mem[look_set][wr_way] <= st_val;
            if (plru_we) plru_mem[look_set]       <= plru_next;
        end
    end

    always_ff @(posedge clk) begin
        if (tag_we)  tag_mem[look_set][wr_way]   <= look_tag;
        if (data_we) data_mem[{look_set, wr_way}] <= merge_out;
    end

    assign req_ready  = (c_q.fsm == CF_IDLE);
    assign resp_valid = c_q.resp_valid;
    assign resp_rdata = c_q.resp_rdata;

    // Checks on the control and the memory port
    logic accept_q;
    assign accept_q = req_valid && req_ready && !req_ci;

    AST_MEM_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready); // R10

    AST_RESP_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> req_ready); // R10

    AST_READ_HIT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_q && hit && !req_write) |=> (resp_valid && !mem_req)); // R2

    AST_WB_HIT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_q && hit && req_write && !req_wt) |=> (resp_valid && !mem_req)); // R4

    AST_EVICT_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_we && !mem_word) |=> (mem_req && !mem_we && !mem_word)); // R4

    AST_WT_MISS_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_q && !hit && req_write && req_wt) |=> (mem_req && mem_we && mem_word)); // R6

    AST_INHIBIT_WORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && c_q.ci) |-> mem_word); // R7

    AST_VICTIM_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_q && !hit && (set_st[0] == LS_INV || set_st[1] == LS_INV ||
                              set_st[2] == LS_INV || set_st[3] == LS_INV))
        |-> (set_st[victim_way] == LS_INV)); // R8

endmodule

// File: tb/sim_dcm_cache_top.sv
`timescale 1ns/1ps
module sim_dcm_cache_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic         req_write = 1'b0;
    logic         req_wt = 1'b0;
    logic         req_ci = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         resp_valid;
    logic [31:0]  resp_rdata;
    logic         mem_req;
    logic         mem_we;
    logic         mem_word;
    logic [31:0]  mem_addr;
    logic [255:0] mem_wline;
    logic         mem_ack = 1'b0;
    logic [255:0] mem_rline = '0;

    always #2 clk = ~clk;

    dcm_cache_top u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_wt(req_wt), .req_ci(req_ci), .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word), .mem_addr(mem_addr),
        .mem_wline(mem_wline), .mem_ack(mem_ack), .mem_rline(mem_rline)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_lr = 0, n_lw = 0, n_ww = 0, n_wr = 0;
    bit done = 1'b0;

    logic [31:0] bmem [logic [31:0]];
    logic [31:0] rmem [logic [31:0]];

    function automatic logic [31:0] init_word(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0F0F_1234;
    endfunction

    function automatic logic [31:0] bm_rd(logic [31:0] a);
        return bmem.exists(a) ? bmem[a] : init_word(a);
    endfunction

    function automatic logic [31:0] ref_rd(logic [31:0] a);
        return rmem.exists(a) ? rmem[a] : init_word(a);
    endfunction

    // Memory model: acknowledges one cycle after it sees a request
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (rst_n && mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we && mem_word) begin
                n_ww++;
                bmem[{mem_addr[31:2], 2'b00}] = mem_wline[31:0];
            end else if (mem_we) begin
                n_lw++;
                for (int i = 0; i < 8; i++)
                    bmem[{mem_addr[31:5], 5'b0} + 32'(i*4)] = mem_wline[i*32 +: 32];
            end else if (mem_word) begin
                n_wr++;
                mem_rline <= {224'b0, bm_rd({mem_addr[31:2], 2'b00})};
            end else begin
                n_lr++;
                for (int i = 0; i < 8; i++)
                    mem_rline[i*32 +: 32] <= bm_rd({mem_addr[31:5], 5'b0} + 32'(i*4));
            end
        end
    end

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_op(input bit wr, input bit wt, input bit ci, input logic [31:0] a,
                         input logic [31:0] wd, output int lat, output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wt = wt; req_ci = ci;
        req_addr = a; req_wdata = wd;
        @(posedge clk);
        #1 req_valid = 1'b0;
        if (wr) rmem[{a[31:2], 2'b00}] = wd;
        lat = 0; rd = '0;
        while (lat < 40) begin
            @(negedge clk);
            lat++;
            if (resp_valid) begin
                rd = resp_rdata;
                break;
            end
        end
    endtask

    function automatic logic [31:0] mk(logic [19:0] t, logic [6:0] s, logic [2:0] w);
        return {t, s, w, 2'b00};
    endfunction

    typedef struct packed {
        logic        wr;
        logic        wt;
        logic        ci;
        logic [19:0] tag;
        logic [6:0]  set;
        logic [2:0]  word;
        logic [31:0] wdata;
        logic [3:0]  e_lr;
        logic [3:0]  e_lw;
        logic [3:0]  e_ww;
        logic [3:0]  e_wr;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,20'h00101,7'd3,3'd2,32'h0,4'd1,4'd0,4'd0,4'd0}, // R3 fill way0
        '{1'b0,1'b0,1'b0,20'h00101,7'd3,3'd5,32'h0,4'd0,4'd0,4'd0,4'd0}, // R2 R1
        '{1'b1,1'b0,1'b0,20'h00101,7'd3,3'd5,32'hCAFE0001,4'd0,4'd0,4'd0,4'd0}, // R4 modified
        '{1'b0,1'b0,1'b0,20'h00101,7'd3,3'd5,32'h0,4'd0,4'd0,4'd0,4'd0}, // R2
        '{1'b1,1'b1,1'b0,20'h00202,7'd3,3'd0,32'hCAFE0002,4'd0,4'd0,4'd1,4'd0}, // R6
        '{1'b0,1'b0,1'b0,20'h00202,7'd3,3'd0,32'h0,4'd1,4'd0,4'd0,4'd0}, // R6 R8 way1
        '{1'b0,1'b0,1'b0,20'h00303,7'd3,3'd0,32'h0,4'd1,4'd0,4'd0,4'd0}, // R8 way2
        '{1'b0,1'b0,1'b0,20'h00404,7'd3,3'd0,32'h0,4'd1,4'd0,4'd0,4'd0}, // R8 way3
        '{1'b0,1'b0,1'b0,20'h00505,7'd3,3'd1,32'h0,4'd1,4'd1,4'd0,4'd0}, // R4 R8 evict way0
        '{1'b0,1'b0,1'b0,20'h00101,7'd3,3'd5,32'h0,4'd1,4'd0,4'd0,4'd0}, // R4 data kept, way2
        '{1'b0,1'b0,1'b1,20'h00606,7'd3,3'd3,32'h0,4'd0,4'd0,4'd0,4'd1}, // R7
        '{1'b0,1'b0,1'b1,20'h00606,7'd3,3'd3,32'h0,4'd0,4'd0,4'd0,4'd1}, // R7 no alloc
        '{1'b1,1'b0,1'b1,20'h00606,7'd3,3'd3,32'hCAFE0003,4'd0,4'd0,4'd1,4'd0}, // R7
        '{1'b0,1'b0,1'b0,20'h00606,7'd3,3'd3,32'h0,4'd1,4'd0,4'd0,4'd0}, // R8 way1
        '{1'b1,1'b1,1'b0,20'h00606,7'd3,3'd3,32'hCAFE0004,4'd0,4'd0,4'd1,4'd0}, // R5
        '{1'b0,1'b0,1'b0,20'h00606,7'd3,3'd3,32'h0,4'd0,4'd0,4'd0,4'd0}, // R5 hit
        '{1'b0,1'b0,1'b0,20'h00707,7'd3,3'd0,32'h0,4'd1,4'd0,4'd0,4'd0}, // R8 way3
        '{1'b0,1'b0,1'b0,20'h00808,7'd3,3'd0,32'h0,4'd1,4'd0,4'd0,4'd0}, // R8 way0
        '{1'b0,1'b0,1'b0,20'h00909,7'd3,3'd0,32'h0,4'd1,4'd0,4'd0,4'd0}, // R8 way2
        '{1'b0,1'b0,1'b0,20'h00A0A,7'd3,3'd0,32'h0,4'd1,4'd0,4'd0,4'd0}, // R5 clean evict way1
        '{1'b1,1'b0,1'b0,20'h00B0B,7'd3,3'd4,32'hCAFE0005,4'd1,4'd0,4'd0,4'd0}, // R9 way3
        '{1'b0,1'b0,1'b0,20'h00B0B,7'd3,3'd4,32'h0,4'd0,4'd0,4'd0,4'd0}, // R9 hit
        '{1'b0,1'b0,1'b0,20'h00101,7'd5,3'd5,32'h0,4'd1,4'd0,4'd0,4'd0}  // R1 other set
    };

    function automatic string req_of(vec_t v);
        if (v.ci) return "R7";
        if (v.wr && v.wt) return "R5|R6";
        if (v.wr) return (v.e_lr != 0) ? "R9" : "R4";
        if (v.e_lw != 0) return "R4";
        if (v.e_lr != 0) return "R3|R8";
        return "R2";
    endfunction

    initial begin
        int lat;
        logic [31:0] rd;
        int b_lr, b_lw, b_ww, b_wr, e_lat;
        logic [31:0] a;

        repeat (3) @(negedge clk);
        // R11: reset state
        check(req_ready === 1'b1, "R11", "ready in reset", 32'(req_ready), 1);
        check(resp_valid === 1'b0, "R11", "resp in reset", 32'(resp_valid), 0);
        check(mem_req === 1'b0, "R11", "mem_req in reset", 32'(mem_req), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = TBL[i];
            a = mk(v.tag, v.set, v.word);
            b_lr = n_lr; b_lw = n_lw; b_ww = n_ww; b_wr = n_wr;
            e_lat = 1 + 2 * int'(v.e_lr + v.e_lw + v.e_ww + v.e_wr);
            do_op(v.wr, v.wt, v.ci, a, v.wdata, lat, rd);
            check(lat == e_lat, req_of(v), $sformatf("latency step %0d", i), 32'(lat), 32'(e_lat));
            check((n_lr - b_lr) == int'(v.e_lr) && (n_lw - b_lw) == int'(v.e_lw) &&
                  (n_ww - b_ww) == int'(v.e_ww) && (n_wr - b_wr) == int'(v.e_wr),
                  req_of(v), $sformatf("traffic step %0d (lr lw ww wr)", i),
                  {8'(n_lr-b_lr), 8'(n_lw-b_lw), 8'(n_ww-b_ww), 8'(n_wr-b_wr)},
                  {8'(v.e_lr), 8'(v.e_lw), 8'(v.e_ww), 8'(v.e_wr)});
            if (!v.wr)
                check(rd === ref_rd(a), req_of(v), $sformatf("read data step %0d", i), rd, ref_rd(a));
        end

        // R1: another word of the line filled in set 5 hits
        a = mk(20'h00101, 7'd5, 3'd7);
        do_op(1'b0, 1'b0, 1'b0, a, 32'h0, lat, rd);
        check(lat == 1, "R1", "same line other word latency", 32'(lat), 1);
        check(rd === ref_rd(a), "R1", "same line other word data", rd, ref_rd(a));

        // R10: busy during a miss, a request offered while busy is ignored
        a = mk(20'h00C0C, 7'd9, 3'd0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_wt = 1'b0; req_ci = 1'b0; req_addr = a;
        @(posedge clk);
        #1 req_write = 1'b1; req_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        check(req_ready === 1'b0, "R10", "ready while busy", 32'(req_ready), 0);
        check(mem_req === 1'b1, "R10", "mem_req while busy", 32'(mem_req), 1);
        @(negedge clk);
        req_valid = 1'b0;
        b_lr = 0;
        while (!resp_valid && b_lr < 20) begin
            @(negedge clk);
            b_lr++;
        end
        check(resp_rdata === ref_rd(a), "R10", "busy miss data", resp_rdata, ref_rd(a));
        b_ww = n_ww;
        do_op(1'b0, 1'b0, 1'b0, a, 32'h0, lat, rd);
        check(rd === ref_rd(a), "R10", "ignored store left data", rd, ref_rd(a));
        check(lat == 1 && n_ww == b_ww, "R10", "ignored store no traffic", 32'(lat), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule